// File: doc/BRIEF.md
# Parallel reflected CRC-16 engine

The block computes a 16-bit cyclic redundancy check with generator x^16 + x^12 + x^5 + 1 (0x1021), zero preset, zero output mask, and reflection on both input and output. It absorbs one 32-bit word per clock. Inside a single cycle, the word is split into bytes and run through a chain of combinational byte updates. Each byte enters least significant bit first, and the remainder left by one byte feeds the next byte.

The remainder carries over from word to word until a start request resets it to the preset value. A message whose length is not a multiple of four bytes ends with a partial word. A byte count input tells the block how many bytes of that word to use, counted from the top. When a word flagged as the last one has been absorbed, the block registers the bit-reversed and masked remainder and raises a one-cycle valid flag.

Top module: `crc16_refl_par`

## Requirements
- R1: After the asynchronous active-low reset, crc_o is 0x0000, crc_valid_o is 0, and the running remainder equals the preset 0x0000. A first word sent without start_i therefore gives the same result as one sent with start_i.
- R2: The single-word message 0x54091010 (all four bytes, last) gives crc_o = 0xBEF4. It must give neither 0x3019 (no reflection) nor 0x980C (whole-word reversal).
- R3: Bytes are taken from bits 31:24 first, then 23:16, 15:8 and 7:0. Each byte is consumed least significant bit first.
- R4: The remainder carries from one valid word to the next. Cycles with data_valid_i low and start_i low leave it unchanged.
- R5: When start_i and data_valid_i are both high, the word is folded into the preset value, not into the previous remainder.
- R6: start_i high with data_valid_i low loads the preset into the remainder at that edge.
- R7: bcnt_i = n selects n+1 bytes, taken from the top of data_i. The bytes below them have no effect on the result.
- R8: crc_valid_o is high for exactly the cycle after an edge where data_valid_i and last_i were both high. crc_o is updated at that edge and holds at all other times.
- R9: The ASCII message "123456789" gives 0x2189.
- R10: A message followed by its own CRC, low byte first, gives 0x0000.
- R11: last_i with data_valid_i low does not raise crc_valid_o and does not change crc_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Restart message from the preset |
| data_valid_i | input | 1 | data_i carries a word to absorb |
| data_i | input | 32 | Data word, first byte in bits 31:24 |
| bcnt_i | input | 2 | Valid bytes in the word minus one |
| last_i | input | 1 | Word ends the message |
| crc_o | output | 16 | Registered final CRC |
| crc_valid_o | output | 1 | One-cycle strobe for a new crc_o |

## Verification
The hardest case to reach from the ports is a partial final word whose unused low byte lanes hold nonzero junk. It matters most when it follows a remainder left dirty by an unfinished message, or when a start request arrives together with that word. The stimulus sets this up directly: it fills the unused lanes with deliberate garbage and leaves messages unfinished before issuing start, both with and without a word in the same cycle. A randomized run then mixes byte counts, starts, idle gaps and last flags. Every cycle is compared against a bit-serial model that runs on the reflected register.

// File: rtl/crc16r_pkg.sv
package crc16r_pkg;
  localparam int CRC_W  = 16;
  localparam int BYTE_W = 8;
  typedef logic [CRC_W-1:0]  crc_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // normal-form register, byte entered lsb first (reflected input)
  function automatic crc_t crc_byte_upd(crc_t c, byte_t b, crc_t poly);
    crc_t r;
    logic fb;
    r = c;
    for (int i = 0; i < BYTE_W; i++) begin
      fb = r[CRC_W-1] ^ b[i];
      r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    end
    return r;
  endfunction
endpackage

// File: rtl/crc_word_fold.sv
module crc_word_fold
  import crc16r_pkg::*;
#(
  parameter int   WORD_BYTES = 4,
  parameter crc_t POLY       = 16'h1021,
  localparam int  WORD_W     = WORD_BYTES * BYTE_W,
  localparam int  CNT_W      = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1
) (
  input  crc_t              seed_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output crc_t              crc_o
);
  crc_t acc;
  crc_t sel;

  // chained byte steps, top byte first; tap after byte cnt_i
  always_comb begin
    acc = seed_i;
    sel = seed_i;
    for (int g = 0; g < WORD_BYTES; g++) begin
      acc = crc_byte_upd(acc, word_i[(WORD_BYTES-1-g)*BYTE_W +: BYTE_W], POLY);
      if (g == int'(cnt_i)) sel = acc;
    end
  end

  assign crc_o = sel;
endmodule

// File: rtl/crc_out_fmt.sv
module crc_out_fmt
  import crc16r_pkg::*;
#(
  parameter crc_t XOROUT = 16'h0000,
  parameter bit   REFOUT = 1'b1
) (
  input  crc_t rem_i,
  output crc_t crc_o
);
  crc_t ord;

  if (REFOUT) begin : g_rev
    for (genvar i = 0; i < CRC_W; i++) begin : g_bit
      assign ord[i] = rem_i[CRC_W-1-i];
    end
  end else begin : g_thru
    assign ord = rem_i;
  end

  assign crc_o = ord ^ XOROUT;
endmodule

// File: rtl/crc16_refl_par.sv
module crc16_refl_par
  import crc16r_pkg::*;
#(
  parameter int   WORD_BYTES = 4,
  parameter crc_t POLY       = 16'h1021,
  parameter crc_t INIT       = 16'h0000,
  parameter crc_t XOROUT     = 16'h0000,
  localparam int  WORD_W     = WORD_BYTES * BYTE_W,
  localparam int  CNT_W      = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              data_valid_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [CNT_W-1:0]  bcnt_i,
  input  logic              last_i,
  output logic [CRC_W-1:0]  crc_o,
  output logic              crc_valid_o
);
  crc_t rem_q, seed, fold, fmt, crc_q;
  logic vld_q;

  assign seed = start_i ? INIT : rem_q;

  crc_word_fold #(.WORD_BYTES(WORD_BYTES), .POLY(POLY)) u_fold (
    .seed_i(seed), .word_i(data_i), .cnt_i(bcnt_i), .crc_o(fold)
  );

  crc_out_fmt #(.XOROUT(XOROUT), .REFOUT(1'b1)) u_fmt (
    .rem_i(fold), .crc_o(fmt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= INIT;
      crc_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= data_valid_i & last_i;
      if (data_valid_i) begin
        rem_q <= fold;
        if (last_i) crc_q <= fmt;
      end else if (start_i) begin
        rem_q <= INIT;
      end
    end
  end

  assign crc_o       = crc_q;
  assign crc_valid_o = vld_q;

  // R8
  valid_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_valid_i && last_i) |=> crc_valid_o);
  // R8 R11
  no_spurious_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(data_valid_i && last_i) |=> !crc_valid_o);
  // R8
  crc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !crc_valid_o |-> $stable(crc_o));
  // R4
  rem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!data_valid_i && !start_i) |=> $stable(rem_q));
  // R6
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !data_valid_i) |=> (rem_q == INIT));
endmodule

// File: tb/sim_crc16_refl_par.sv
module sim_crc16_refl_par;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, dv = 1'b0, last = 1'b0;
  logic [31:0] data = '0;
  logic [1:0]  bcnt = '0;
  logic [15:0] crc;
  logic        crc_vld;

  int checks = 0, fails = 0;
  bit done = 0;

  // reflected-register bit-serial model
  logic [15:0] m_rem = 16'h0000, m_crc = 16'h0000;
  logic        m_vld = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  crc16_refl_par u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .data_valid_i(dv),
    .data_i(data), .bcnt_i(bcnt), .last_i(last),
    .crc_o(crc), .crc_valid_o(crc_vld)
  );

  function automatic logic [15:0] ref_byte(logic [15:0] c, logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if ((r[0] ^ b[i]) == 1'b1) r = (r >> 1) ^ 16'h8408;
      else                       r = r >> 1;
    end
    return r;
  endfunction

  task automatic chk16(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_ne(string tag, logic [15:0] act, logic [15:0] bad);
    checks++;
    if (act === bad) begin
      fails++;
      $display("FAIL %s actual=%h expected!=%h", tag, act, bad);
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(logic st, logic v, logic [31:0] d, logic [1:0] n, logic l, string tag);
    logic [15:0] c;
    start = st; dv = v; data = d; bcnt = n; last = l;
    @(posedge clk);
    if (v) begin
      c = st ? 16'h0000 : m_rem;
      for (int k = 0; k <= int'(n); k++) c = ref_byte(c, d[31-8*k -: 8]);
      m_rem = c;
      if (l) m_crc = c;
    end else if (st) begin
      m_rem = 16'h0000;
    end
    m_vld = v & l;
    @(negedge clk);
    chk16({tag, " crc_o"}, crc, m_crc);
    chk16({tag, " crc_valid_o"}, {15'd0, crc_vld}, {15'd0, m_vld});
  endtask

  task automatic idle(string tag);
    cyc(1'b0, 1'b0, 32'hDEAD_BEEF, 2'd3, 1'b0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk16("R1 reset crc_o", crc, 16'h0000);
    chk16("R1 reset crc_valid_o", {15'd0, crc_vld}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R1: first word without start, whole message
    cyc(1'b0, 1'b1, 32'h5409_1010, 2'd3, 1'b1, "R2");
    chk16("R2 known word", crc, 16'hBEF4);
    chk_ne("R2 not unreflected", crc, 16'h3019);
    chk_ne("R2 not whole-word reversal", crc, 16'h980C);
    idle("R8 drop");
    chk16("R8 crc_o held", crc, 16'hBEF4);

    // R3 byte order: swapped word must differ, model gives value
    cyc(1'b1, 1'b1, 32'h1010_0954, 2'd3, 1'b1, "R3");
    chk_ne("R3 byte order", crc, 16'hBEF4);

    // R9 R4 R7 check string with idle gaps and junk lanes
    cyc(1'b1, 1'b1, 32'h3132_3334, 2'd3, 1'b0, "R9 w0");
    idle("R4 gap");
    idle("R4 gap");
    cyc(1'b0, 1'b1, 32'h3536_3738, 2'd3, 1'b0, "R9 w1");
    cyc(1'b0, 1'b1, 32'h39AB_CDEF, 2'd0, 1'b1, "R7 R9 tail");
    chk16("R9 check value", crc, 16'h2189);

    // R10 residue: message plus crc low byte first
    cyc(1'b1, 1'b1, 32'h3132_3334, 2'd3, 1'b0, "R10 w0");
    cyc(1'b0, 1'b1, 32'h3536_3738, 2'd3, 1'b0, "R10 w1");
    cyc(1'b0, 1'b1, 32'h3989_2155, 2'd2, 1'b1, "R10 R7 tail");
    chk16("R10 residue", crc, 16'h0000);

    // R6 start alone clears a dirty remainder
    cyc(1'b1, 1'b1, 32'hFFFF_0000, 2'd3, 1'b0, "R6 dirty");
    cyc(1'b1, 1'b0, 32'h0, 2'd0, 1'b0, "R6 start");
    cyc(1'b0, 1'b1, 32'h5409_1010, 2'd3, 1'b1, "R6");
    chk16("R6 after clear", crc, 16'hBEF4);

    // R5 start with word over dirty remainder
    cyc(1'b0, 1'b1, 32'h1234_5678, 2'd3, 1'b0, "R5 dirty");
    cyc(1'b1, 1'b1, 32'h5409_1010, 2'd3, 1'b1, "R5");
    chk16("R5 start with word", crc, 16'hBEF4);

    // R11 last without valid
    cyc(1'b0, 1'b0, 32'h0000_0001, 2'd3, 1'b1, "R11");
    chk16("R11 crc_o held", crc, 16'hBEF4);
    chk16("R11 no strobe", {15'd0, crc_vld}, 16'h0000);

    // R3 R4 R7 R8 randomized traffic
    for (int i = 0; i < 300; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      cyc(rv[0] & rv[1] & rv[2], rv[3] | rv[4], $urandom, rv[6:5], rv[7] & rv[8], "R3 R7 random");
    end

    finish_run();
  end
endmodule